// File: doc/BRIEF.md
# Word-Packing External Memory Bridge

This block connects an internal requester that moves 16-bit or 24-bit words to an external memory bus whose data path is either 8 or 16 bits wide. It breaks each internal word into the number of external bus cycles the selected width requires. Bytes go out or come in least significant first, at consecutive external addresses. Read data is reassembled and handed back as a whole word. The external address is 22 bits wide. Each external cycle waits for an acknowledge from the memory before it moves on.

A configuration input selects the external width, and the bridge samples it once per access when it accepts the request. In the 8-bit width, memory traffic uses only the low eight data lines. The upper eight lines then act as general-purpose bidirectional flag pins. Each pin has its own output-enable bit and its own output-value bit, both held in registers. The present level of the pins can always be read back.

On the internal side the requester raises a request and holds it until a one-clock ready pulse appears. For reads, the assembled word is valid during that pulse.

Top module: `wpack_xmem`

## Requirements
- R1: After reset, `xa_strobe`, `xa_we`, `req_ready`, `xd_oe_lo` and every bit of `xd_oe_hi` are low, and the flag direction and output registers are zero.
- R2: The number of acknowledged external cycles per access is 2 for a 16-bit word on the 8-bit bus (`cfg_narrow`=1), 3 for a 24-bit word (`req_wide`=1) on the 8-bit bus, 2 for a 24-bit word on the 16-bit bus (`cfg_narrow`=0) and 1 for a 16-bit word on the 16-bit bus.
- R3: Beat k of an access presents address `req_addr`+k, modulo 2^22. On the 8-bit bus, beat k carries word bits [8k+7:8k] on `xd_out[7:0]`.
- R4: For a 24-bit word on the 16-bit bus, beat 0 carries word bits [15:0] on `xd_out[15:0]`. Beat 1 carries word bits [23:16] on `xd_out[7:0]`, with `xd_oe_hi` low.
- R5: While `xa_strobe` is high and `xa_ack` is low, the address, write flag and low-lane data hold their values. Data on `xd_in` is captured only in a cycle where `xa_ack` is high.
- R6: `req_ready` is high for exactly one clock, in the cycle after the final acknowledged beat, and `xa_strobe` is low in that cycle. For reads, `req_rdata` then holds the assembled word, with bits [23:16] zero for a 16-bit word.
- R7: During write beats `xa_we` and `xd_oe_lo` are high. During read beats both are low, and on the 16-bit bus `xd_oe_hi` is also low.
- R8: With the 8-bit width in effect, `xd_oe_hi` equals the flag direction register and `xd_out[15:8]` equals the flag output register, also during accesses. `flag_dir_we` and `flag_out_we` load `flag_wdata` into these registers on the next edge. `flag_in` always equals `xd_in[15:8]`.
- R9: With the 16-bit width in effect and no access running, `xd_oe_hi` is all low. The flag registers keep their contents and reappear when the 8-bit width is selected again.
- R10: The width is fixed when the access is accepted, so changing `cfg_narrow` during an access has no effect on that access. A request still held high while `req_ready` is high does not start a new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_narrow | input | 1 | 1 selects the 8-bit external bus, 0 the 16-bit bus |
| req_valid | input | 1 | Internal request, held until `req_ready` |
| req_addr | input | 22 | External base address of the word |
| req_wide | input | 1 | 1 for a 24-bit word, 0 for a 16-bit word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 24 | Write word |
| req_ready | output | 1 | One-clock completion pulse |
| req_rdata | output | 24 | Assembled read word, valid with `req_ready` |
| xa_addr | output | 22 | External address |
| xa_strobe | output | 1 | External cycle in progress |
| xa_we | output | 1 | External write |
| xa_ack | input | 1 | External acknowledge, sampled at the clock edge |
| xd_out | output | 16 | Data driven toward the pins |
| xd_oe_lo | output | 1 | Output enable for lines 7:0 |
| xd_oe_hi | output | 8 | Per-line output enable for lines 15:8 |
| xd_in | input | 16 | Level present on the data pins |
| flag_dir_we | input | 1 | Load the flag direction register |
| flag_out_we | input | 1 | Load the flag output register |
| flag_wdata | input | 8 | Value for either flag register |
| flag_in | output | 8 | Level of the upper eight data pins |

## Verification
The assertions rely on the external memory raising `xa_ack` only while `xa_strobe` is high. They also rely on the requester holding its address, size, direction and data unchanged from the request until the ready pulse. The bench acts as both sides: it drives acknowledges only inside strobe cycles, with zero to two wait cycles per beat. It keeps every request field constant until one cycle after ready, and in that extra cycle the request is still held high on purpose.

// File: rtl/wpack_pkg.sv
package wpack_pkg;

    parameter int XM_ADDR_W = 22;
    parameter int XM_BUS_W  = 16;
    parameter int XM_LANE_W = 8;
    parameter int XM_WORD_W = 24;
    parameter int XM_FLAG_W = XM_BUS_W - XM_LANE_W;
    parameter int XM_BEAT_W = 2;

    typedef logic [XM_ADDR_W-1:0] xaddr_t;
    typedef logic [XM_WORD_W-1:0] xword_t;
    typedef logic [XM_BUS_W-1:0]  xbus_t;
    typedef logic [XM_BEAT_W-1:0] xbeat_t;
    typedef logic [XM_FLAG_W-1:0] xflag_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUS  = 1'b1
    } seq_state_e;

    typedef struct packed {
        xaddr_t addr;
        xword_t data;
        logic   wide;
        logic   write;
        logic   narrow;
    } xreq_t;

    // Beats needed for one word on the chosen external width.
    function automatic xbeat_t beats_needed(input logic narrow, input logic wide);
        if (narrow)
            return wide ? xbeat_t'(3) : xbeat_t'(2);
        return wide ? xbeat_t'(2) : xbeat_t'(1);
    endfunction

    // Lane contents of beat k for an outgoing word.
    function automatic xbus_t lane_slice(input logic narrow, input xword_t word, input xbeat_t beat);
        int unsigned base;
        xbus_t       res;
        res = '0;
        if (narrow) begin
            base = XM_LANE_W * int'(beat);
            res[XM_LANE_W-1:0] = word[base +: XM_LANE_W];
        end else if (beat == '0) begin
            res = word[XM_BUS_W-1:0];
        end else begin
            res[XM_WORD_W-XM_BUS_W-1:0] = word[XM_WORD_W-1:XM_BUS_W];
        end
        return res;
    endfunction

    // Merge the pins captured on beat k into the partial word.
    function automatic xword_t merge_beat(input logic narrow, input xword_t part,
                                          input xbus_t pins, input xbeat_t beat);
        int unsigned base;
        xword_t      res;
        res = part;
        if (narrow) begin
            base = XM_LANE_W * int'(beat);
            res[base +: XM_LANE_W] = pins[XM_LANE_W-1:0];
        end else if (beat == '0) begin
            res[XM_BUS_W-1:0] = pins;
        end else begin
            res[XM_WORD_W-1:XM_BUS_W] = pins[XM_WORD_W-XM_BUS_W-1:0];
        end
        return res;
    endfunction

endpackage

// File: rtl/wpack_seq.sv
module wpack_seq
    import wpack_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   ack,
    input  xbeat_t beats_in,
    output logic   accept,
    output logic   busy,
    output logic   step,
    output logic   done,
    output xbeat_t beat,
    output logic   ready
);

    seq_state_e state_q;
    xbeat_t     beat_q;
    xbeat_t     total_q;
    logic       ready_q;
    logic       last;

    assign accept = (state_q == SEQ_IDLE) && req_valid && !ready_q;
    assign busy   = (state_q == SEQ_BUS);
    assign step   = busy && ack;
    assign last   = (beat_q == total_q - xbeat_t'(1));
    assign done   = step && last;
    assign beat   = beat_q;
    assign ready  = ready_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            beat_q  <= '0;
            total_q <= xbeat_t'(1);
            ready_q <= 1'b0;
        end else begin
            ready_q <= done;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (accept) begin
                        state_q <= SEQ_BUS;
                        beat_q  <= '0;
                        total_q <= beats_in;
                    end
                end
                SEQ_BUS: begin
                    if (step) begin
                        if (last) begin
                            state_q <= SEQ_IDLE;
                            beat_q  <= '0;
                        end else begin
                            beat_q <= beat_q + xbeat_t'(1);
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wpack_lane.sv
module wpack_lane
    import wpack_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   accept,
    input  xreq_t  req_in,
    input  logic   step,
    input  logic   done,
    input  xbeat_t beat,
    input  xbus_t  pins_in,
    output xaddr_t bus_addr,
    output xbus_t  bus_data,
    output logic   hi_mem,
    output logic   cur_write,
    output logic   cur_narrow,
    output xword_t rdata
);

    xreq_t  cur_q;
    xword_t part_q;
    xword_t part_nx;
    xword_t rdata_q;

    assign part_nx    = merge_beat(cur_q.narrow, part_q, pins_in, beat);
    assign bus_addr   = cur_q.addr + xaddr_t'(beat);
    assign bus_data   = lane_slice(cur_q.narrow, cur_q.data, beat);
    assign hi_mem     = !cur_q.narrow && (beat == '0);
    assign cur_write  = cur_q.write;
    assign cur_narrow = cur_q.narrow;
    assign rdata      = rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            part_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                cur_q  <= req_in;
                part_q <= '0;
            end else if (step) begin
                part_q <= part_nx;
            end
            if (done) begin
                rdata_q <= cur_q.wide ? part_nx
                                      : {{(XM_WORD_W-XM_BUS_W){1'b0}}, part_nx[XM_BUS_W-1:0]};
            end
        end
    end

endmodule

// File: rtl/wpack_flags.sv
module wpack_flags
    import wpack_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   dir_we,
    input  logic   out_we,
    input  xflag_t wdata,
    output xflag_t dir,
    output xflag_t level
);

    xflag_t dir_q;
    xflag_t lvl_q;

    assign dir   = dir_q;
    assign level = lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            lvl_q <= '0;
        end else begin
            if (dir_we) dir_q <= wdata;
            if (out_we) lvl_q <= wdata;
        end
    end

endmodule

// File: rtl/wpack_xmem.sv
module wpack_xmem
    import wpack_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_narrow,
    input  logic                 req_valid,
    input  logic [XM_ADDR_W-1:0] req_addr,
    input  logic                 req_wide,
    input  logic                 req_write,
    input  logic [XM_WORD_W-1:0] req_wdata,
    output logic                 req_ready,
    output logic [XM_WORD_W-1:0] req_rdata,
    output logic [XM_ADDR_W-1:0] xa_addr,
    output logic                 xa_strobe,
    output logic                 xa_we,
    input  logic                 xa_ack,
    output logic [XM_BUS_W-1:0]  xd_out,
    output logic                 xd_oe_lo,
    output logic [XM_FLAG_W-1:0] xd_oe_hi,
    input  logic [XM_BUS_W-1:0]  xd_in,
    input  logic                 flag_dir_we,
    input  logic                 flag_out_we,
    input  logic [XM_FLAG_W-1:0] flag_wdata,
    output logic [XM_FLAG_W-1:0] flag_in
);

    xreq_t  req_pack;
    xbeat_t beats_in;
    logic   accept;
    logic   busy;
    logic   step;
    logic   done;
    xbeat_t beat;
    xbus_t  lane_data;
    logic   hi_mem;
    logic   cur_write;
    logic   cur_narrow;
    logic   narrow_eff;
    xflag_t fdir;
    xflag_t flvl;

    assign req_pack = '{addr: req_addr, data: req_wdata, wide: req_wide,
                        write: req_write, narrow: cfg_narrow};
    assign beats_in = beats_needed(cfg_narrow, req_wide);

    wpack_seq i_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .ack      (xa_ack),
        .beats_in (beats_in),
        .accept   (accept),
        .busy     (busy),
        .step     (step),
        .done     (done),
        .beat     (beat),
        .ready    (req_ready)
    );

    wpack_lane i_lane (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_in    (req_pack),
        .step      (step),
        .done      (done),
        .beat      (beat),
        .pins_in   (xd_in),
        .bus_addr  (xa_addr),
        .bus_data  (lane_data),
        .hi_mem    (hi_mem),
        .cur_write (cur_write),
        .cur_narrow(cur_narrow),
        .rdata     (req_rdata)
    );

    wpack_flags i_flags (
        .clk   (clk),
        .rst   (rst),
        .dir_we(flag_dir_we),
        .out_we(flag_out_we),
        .wdata (flag_wdata),
        .dir   (fdir),
        .level (flvl)
    );

    assign narrow_eff = busy ? cur_narrow : cfg_narrow;
    assign xa_strobe  = busy;
    assign xa_we      = busy && cur_write;
    assign xd_oe_lo   = busy && cur_write;
    assign flag_in    = xd_in[XM_BUS_W-1:XM_LANE_W];

    always_comb begin
        xd_out[XM_LANE_W-1:0] = lane_data[XM_LANE_W-1:0];
        if (narrow_eff) begin
            xd_out[XM_BUS_W-1:XM_LANE_W] = flvl;
            xd_oe_hi                     = fdir;
        end else begin
            xd_out[XM_BUS_W-1:XM_LANE_W] = lane_data[XM_BUS_W-1:XM_LANE_W];
            xd_oe_hi                     = {XM_FLAG_W{busy && cur_write && hi_mem}};
        end
    end

endmodule

// File: rtl/wpack_xmem_chk.sv
module wpack_xmem_chk
    import wpack_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 xa_strobe,
    input logic                 xa_ack,
    input logic                 xa_we,
    input logic [XM_ADDR_W-1:0] xa_addr,
    input logic [XM_BUS_W-1:0]  xd_out,
    input logic                 xd_oe_lo,
    input logic                 req_ready
);

    logic [2:0] ack_cnt;

    always_ff @(posedge clk) begin
        if (rst || req_ready) ack_cnt <= '0;
        else if (xa_strobe && xa_ack) ack_cnt <= ack_cnt + 3'd1;
    end

    // R5: a beat without acknowledge keeps its address, direction and low lane
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (xa_strobe && !xa_ack) |=> (xa_strobe && $stable(xa_addr) && $stable(xa_we)
                                    && $stable(xd_out[XM_LANE_W-1:0])));

    // R3: the next beat of the same access uses the next address
    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        (xa_strobe && $past(xa_strobe && xa_ack)) |-> (xa_addr == $past(xa_addr) + 22'd1));

    // R6: ready is a single-cycle pulse that follows an acknowledged beat
    a_r6_one_pulse: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);
    a_r6_after_ack: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> ($past(xa_strobe && xa_ack) && !xa_strobe));

    // R2: an access completes after one to three acknowledged beats
    a_r2_beat_span: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (ack_cnt >= 3'd1 && ack_cnt <= 3'd3));

    // R10: no new access begins in the cycle after the ready pulse
    a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !xa_strobe);

    // R7: the low lane is driven only in write beats
    a_r7_low_drive: assert property (@(posedge clk) disable iff (rst)
        xd_oe_lo |-> (xa_strobe && xa_we));

endmodule

bind wpack_xmem wpack_xmem_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .xa_strobe(xa_strobe),
    .xa_ack   (xa_ack),
    .xa_we    (xa_we),
    .xa_addr  (xa_addr),
    .xd_out   (xd_out),
    .xd_oe_lo (xd_oe_lo),
    .req_ready(req_ready)
);

// File: tb/test_wpack_xmem.sv
module test_wpack_xmem;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_narrow;
    logic        req_valid;
    logic [21:0] req_addr;
    logic        req_wide;
    logic        req_write;
    logic [23:0] req_wdata;
    logic        req_ready;
    logic [23:0] req_rdata;
    logic [21:0] xa_addr;
    logic        xa_strobe;
    logic        xa_we;
    logic        xa_ack;
    logic [15:0] xd_out;
    logic        xd_oe_lo;
    logic [7:0]  xd_oe_hi;
    logic [15:0] xd_in;
    logic        flag_dir_we;
    logic        flag_out_we;
    logic [7:0]  flag_wdata;
    logic [7:0]  flag_in;

    int total = 0;
    int bad   = 0;
    bit over  = 0;

    logic [7:0]  m_fdir = '0;
    logic [7:0]  m_fout = '0;
    logic [15:0] mem [logic [21:0]];

    always #5 clk = ~clk;

    wpack_xmem i_wpack_xmem (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] mem_rd(input logic [21:0] a);
        if (mem.exists(a)) return mem[a];
        return {a[7:0] ^ 8'h5A, a[15:8] + 8'h33};
    endfunction

    task automatic set_flags(input logic [7:0] d, input logic [7:0] o);
        @(negedge clk);
        flag_dir_we = 1'b1; flag_out_we = 1'b0; flag_wdata = d;
        @(negedge clk);
        flag_dir_we = 1'b0; flag_out_we = 1'b1; flag_wdata = o;
        @(negedge clk);
        flag_out_we = 1'b0;
        m_fdir = d; m_fout = o;
    endtask

    // One internal access with the bench acting as the external memory.
    task automatic access(input bit nar, input bit wide, input bit we, input logic [21:0] a,
                          input logic [23:0] wd, input int wsel, input bit flip);
        int          n;
        logic [23:0] exp_rd;
        @(negedge clk);
        cfg_narrow = nar; req_valid = 1'b1; req_addr = a; req_wide = wide;
        req_write = we; req_wdata = wd; xa_ack = 1'b0;
        n = nar ? (wide ? 3 : 2) : (wide ? 2 : 1);
        exp_rd = '0;
        for (int k = 0; k < n; k++) begin
            logic [21:0] ba;
            logic [15:0] ev;
            int          w;
            ba = a + 22'(k);
            w  = (k + wsel) % 3;
            if (nar) ev = {8'h00, wd[8*k +: 8]};
            else if (k == 0) ev = wd[15:0];
            else ev = {8'h00, wd[23:16]};
            for (int c = 0; c <= w; c++) begin
                @(negedge clk);
                if (flip && k == 0 && c == 0) cfg_narrow = !nar;   // R10: no effect expected
                chk("R5 strobe held", 32'(xa_strobe), 32'd1);
                chk("R3 beat address", 32'(xa_addr), 32'(ba));
                chk("R7 write flag", 32'(xa_we), 32'(we));
                chk("R7 low lane enable", 32'(xd_oe_lo), 32'(we));
                chk("R6 ready low mid-access", 32'(req_ready), 32'd0);
                if (we) chk(nar ? "R3 narrow lane data" : "R4 wide lane data",
                            32'(xd_out[7:0]), 32'(ev[7:0]));
                if (nar) begin
                    chk("R8 flag enables in access", 32'(xd_oe_hi), 32'(m_fdir));
                    chk("R8 flag levels in access", 32'(xd_out[15:8]), 32'(m_fout));
                end else begin
                    chk("R4 upper enable", 32'(xd_oe_hi), (we && k == 0) ? 32'hFF : 32'h00);
                    if (we && k == 0) chk("R4 upper lane data", 32'(xd_out[15:8]), 32'(ev[15:8]));
                end
                if (c == w) begin
                    xa_ack = 1'b1;
                    if (nar) begin
                        xd_in = {8'hC3, mem_rd(ba)[7:0]};
                        exp_rd[8*k +: 8] = mem_rd(ba)[7:0];
                        if (we) mem[ba] = {mem_rd(ba)[15:8], ev[7:0]};
                    end else begin
                        xd_in = mem_rd(ba);
                        if (k == 0) exp_rd[15:0] = mem_rd(ba);
                        else exp_rd[23:16] = mem_rd(ba)[7:0];
                        if (we) mem[ba] = (k == 0) ? ev : {mem_rd(ba)[15:8], ev[7:0]};
                    end
                end else begin
                    xa_ack = 1'b0;
                    xd_in  = 16'hDEAD;   // R5: must not be captured
                end
            end
        end
        @(negedge clk);
        xa_ack = 1'b0;
        chk("R6 ready pulse", 32'(req_ready), 32'd1);
        chk("R6 strobe low on ready", 32'(xa_strobe), 32'd0);
        if (!we) chk(wide ? "R6 read word 24" : "R6 read word 16", 32'(req_rdata), 32'(exp_rd));
        @(negedge clk);
        chk("R10 no restart while ready", 32'(xa_strobe), 32'd0);
        chk("R6 ready single cycle", 32'(req_ready), 32'd0);
        req_valid = 1'b0;
        cfg_narrow = nar;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!over) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_narrow = 1'b1; req_valid = 1'b0; req_addr = '0; req_wide = 1'b0;
        req_write = 1'b0; req_wdata = '0; xa_ack = 1'b0; xd_in = 16'h5A00;
        flag_dir_we = 1'b0; flag_out_we = 1'b0; flag_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 strobe", 32'(xa_strobe), 32'd0);
        chk("R1 write", 32'(xa_we), 32'd0);
        chk("R1 ready", 32'(req_ready), 32'd0);
        chk("R1 low enable", 32'(xd_oe_lo), 32'd0);
        chk("R1 flag dir zero", 32'(xd_oe_hi), 32'd0);
        chk("R1 flag out zero", 32'(xd_out[15:8]), 32'd0);

        // R8 flag registers and pin readback
        set_flags(8'hA5, 8'h3C);
        chk("R8 flag enables", 32'(xd_oe_hi), 32'hA5);
        chk("R8 flag levels", 32'(xd_out[15:8]), 32'h3C);
        xd_in = 16'h9E00;
        @(negedge clk);
        chk("R8 flag readback", 32'(flag_in), 32'h9E);

        // R2 R3 R4 R6 R7: all width/size pairs, reads and writes
        access(1'b1, 1'b0, 1'b0, 22'h000100, 24'h0, 0, 1'b0);
        access(1'b1, 1'b1, 1'b0, 22'h000200, 24'h0, 1, 1'b0);
        access(1'b0, 1'b0, 1'b0, 22'h000300, 24'h0, 2, 1'b0);
        access(1'b0, 1'b1, 1'b0, 22'h000400, 24'h0, 0, 1'b0);
        access(1'b1, 1'b1, 1'b1, 22'h3FFFFF, 24'hC0FFEE, 2, 1'b0);  // R3 address wrap
        access(1'b1, 1'b1, 1'b0, 22'h3FFFFF, 24'h0, 0, 1'b0);
        access(1'b0, 1'b1, 1'b1, 22'h001000, 24'h123456, 1, 1'b0);
        access(1'b0, 1'b1, 1'b0, 22'h001000, 24'h0, 2, 1'b0);
        access(1'b1, 1'b0, 1'b1, 22'h002000, 24'hFFBEEF, 0, 1'b0);
        access(1'b1, 1'b0, 1'b0, 22'h002000, 24'h0, 1, 1'b0);
        access(1'b0, 1'b0, 1'b1, 22'h003000, 24'h00A55A, 0, 1'b0);
        access(1'b0, 1'b0, 1'b0, 22'h003000, 24'h0, 0, 1'b0);

        // R10 width change mid-access is ignored
        access(1'b1, 1'b1, 1'b0, 22'h004000, 24'h0, 1, 1'b1);
        access(1'b0, 1'b1, 1'b1, 22'h005000, 24'h778899, 0, 1'b1);

        // R9 wide idle releases upper lines; flags retained
        @(negedge clk);
        cfg_narrow = 1'b0;
        @(negedge clk);
        chk("R9 upper released when wide", 32'(xd_oe_hi), 32'h00);
        cfg_narrow = 1'b1;
        @(negedge clk);
        chk("R9 flag dir retained", 32'(xd_oe_hi), 32'hA5);
        chk("R9 flag out retained", 32'(xd_out[15:8]), 32'h3C);

        over = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule